// File: doc/BRIEF.md
# Oversampled serial receiver with status flags

This block receives asynchronous serial frames on a single line. While receive is enabled, a falling edge on the idle-high line marks a possible start bit. The line is checked again at the middle of that bit. If it is still low, the block shifts in 7 or 8 data bits, in either bit order. An optional parity bit and a stop bit follow. Every bit is sampled once at its centre. Timing comes from an oversampling strobe that pulses 16 times per bit.

At the end of a frame the assembled byte moves to a holding register and a full flag goes high. Software polls or waits for the interrupt. It checks the three error flags, then pulses the read strobe, which empties the holding register. The data counts as good only when the full flag is 1 and all three error flags are 0. Error flags stay set until a separate clear strobe is pulsed.

Top module: `uart_rx_flags`

## Requirements
- R1: While `rx_en` is 0, the receiver stays idle and no frame completes. Dropping `rx_en` in the middle of a frame abandons that frame, so `full` does not set.
- R2: A low line seen on an oversampling tick starts a frame. The line is checked again 8 ticks later. If it is high then, the start is rejected and the receiver returns to idle.
- R3: When the stop bit is sampled and `full` is 0, the received byte is copied to `rdata` and `full` becomes 1.
- R4: With `msb_first` = 0, the first data bit received lands in `rdata[0]`. With `msb_first` = 1, the first data bit received lands in the top data bit: bit 7 when `len8` = 1, bit 6 when `len8` = 0. When `len8` = 0, `rdata[7]` is 0.
- R5: A cycle with `rd_stb` = 1 clears `full` on the next clock edge.
- R6: When `par_en` = 1, one parity bit follows the data. With `par_odd` = 0 the expected parity is even (data bits plus parity bit contain an even number of ones). With `par_odd` = 1 it is odd. A mismatch sets `perr`.
- R7: If a frame completes while `full` is 1, `oerr` is set and `rdata` keeps the earlier byte.
- R8: A stop bit sampled low sets `ferr`. The byte is still delivered under R3.
- R9: A pulse on `clr_err` clears `perr`, `oerr` and `ferr`.
- R10: `irq` equals `irq_en` AND (`full` OR any error flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling strobe, 16 pulses per bit time |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial input, high when idle |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| msb_first | input | 1 | 1: first data bit is the most significant bit |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_stb | input | 1 | Read strobe, empties the holding register |
| clr_err | input | 1 | Clears all three error flags |
| irq_en | input | 1 | Interrupt enable |
| rdata | output | 8 | Received byte |
| full | output | 1 | Holding register contains unread data |
| perr | output | 1 | Parity error flag |
| oerr | output | 1 | Overrun error flag |
| ferr | output | 1 | Framing error flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume three things about the inputs:
- The format inputs `len8`, `msb_first`, `par_en` and `par_odd` do not change while a frame is in flight or while an unread byte is held.
- `rd_stb` never arrives in the same cycle a frame completes.
- No frame completes while `rx_en` is low.

The bench meets these by changing the format only between frames with the line idle, and by reading only after a whole frame, stop bit included, has elapsed. The sweep covers every combination of length, bit order and parity mode over several byte patterns. Directed frames then exercise the glitch, abort, overrun, parity and stop-bit cases.

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic       len8,
  input  logic       msb_first,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_stb,
  input  logic       clr_err,
  input  logic       irq_en,
  output logic [7:0] rdata,
  output logic       full,
  output logic       perr,
  output logic       oerr,
  output logic       ferr,
  output logic       irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [2:0] idx;
  logic [7:0] shreg;
  logic pacc, pbad;

  wire [2:0] last_idx = len8 ? 3'd7 : 3'd6;
  wire [2:0] pos      = msb_first ? last_idx - idx : idx;
  wire       samp     = rx_en & tick & (cnt == LAST);
  wire       done     = samp & (st == STOP);
  wire       load     = done & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; idx <= '0; shreg <= '0; pacc <= 1'b0; pbad <= 1'b0;
    end else if (!rx_en) begin
      st <= IDLE;
    end else if (tick) begin
      case (st)
        IDLE: if (!rxd) begin st <= START; cnt <= '0; end
        START: begin
          if (cnt == MID) begin
            cnt <= '0; idx <= '0; shreg <= '0; pacc <= 1'b0; pbad <= 1'b0;
            st <= rxd ? IDLE : DATA;
          end else cnt <= cnt + 1'b1;
        end
        DATA: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            shreg[pos] <= rxd;
            pacc <= pacc ^ rxd;
            idx <= idx + 3'd1;
            if (idx == last_idx) st <= par_en ? PAR : STOP;
          end
        end
        PAR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin pbad <= pacc ^ rxd ^ par_odd; st <= STOP; end
        end
        STOP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; full <= 1'b0; perr <= 1'b0; oerr <= 1'b0; ferr <= 1'b0;
    end else begin
      if (load) begin rdata <= shreg; full <= 1'b1; end
      else if (rd_stb) full <= 1'b0;
      if (clr_err) begin perr <= 1'b0; oerr <= 1'b0; ferr <= 1'b0; end
      if (done) begin
        if (full) oerr <= 1'b1;
        if (pbad & par_en) perr <= 1'b1;
        if (!rxd) ferr <= 1'b1;
      end
    end
  end

  assign irq = irq_en & (full | perr | oerr | ferr);
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       len8,
  input logic       rd_stb,
  input logic [7:0] rdata,
  input logic       full,
  input logic       oerr
);
  a_r1_no_frame_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(full));
  a_r3_held_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_stb) |=> $stable(rdata));
  a_r4_bit7_zero_short: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full) && !$past(len8)) |-> (rdata[7] == 1'b0));
  a_r5_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_stb) |=> !full);
  a_r7_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> $past(full));
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .len8(len8), .rd_stb(rd_stb),
  .rdata(rdata), .full(full), .oerr(oerr)
);

// File: tb/uart_rx_flags_tb.sv
module uart_rx_flags_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rx_en = 1'b0, rxd = 1'b1;
  logic len8 = 1'b1, msb_first = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic rd_stb = 1'b0, clr_err = 1'b0, irq_en = 1'b0;
  logic [7:0] rdata;
  logic full, perr, oerr, ferr, irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_flags u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .rxd(rxd),
    .len8(len8), .msb_first(msb_first), .par_en(par_en), .par_odd(par_odd),
    .rd_stb(rd_stb), .clr_err(clr_err), .irq_en(irq_en),
    .rdata(rdata), .full(full), .perr(perr), .oerr(oerr), .ferr(ferr), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input bit stop_v);
    int n;
    logic p;
    n = len8 ? 8 : 7;
    p = par_odd;
    rxd = 1'b0; wait_n(16);
    for (int i = 0; i < n; i++) begin
      rxd = msb_first ? d[n-1-i] : d[i];
      p = p ^ rxd;
      wait_n(16);
    end
    if (par_en) begin rxd = p ^ flip_par; wait_n(16); end
    rxd = stop_v; wait_n(stop_v ? 16 : 12);
    rxd = 1'b1; wait_n(4);
  endtask

  task automatic read_byte();
    rd_stb = 1'b1; wait_n(1); rd_stb = 1'b0;
  endtask

  task automatic clear_errs();
    clr_err = 1'b1; wait_n(1); clr_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check("reset full", full, 0);
    check("reset flags", {perr, oerr, ferr}, 0);
    check("reset irq", irq, 0);
    check("reset rdata", rdata, 0);

    // R1: disabled receiver ignores a frame
    send(8'h5A, 0, 1);
    check("R1 disabled no full", full, 0);
    rx_en = 1'b1; wait_n(4);

    // R1: abort mid-frame
    rxd = 1'b0; wait_n(40);
    rx_en = 1'b0; wait_n(2); rx_en = 1'b1; rxd = 1'b1; wait_n(200);
    check("R1 abort no full", full, 0);

    // R2: short glitch rejected, then a valid frame is received
    rxd = 1'b0; wait_n(4); rxd = 1'b1; wait_n(40);
    check("R2 glitch rejected", full, 0);
    send(8'hC3, 0, 1);
    check("R2 frame after glitch", rdata, 8'hC3);
    read_byte();

    // R3 R4 R6: sweep of length, order, parity mode and patterns
    for (int l = 0; l < 2; l++)
      for (int m = 0; m < 2; m++)
        for (int pm = 0; pm < 3; pm++)
          foreach (pats[k]) begin
            len8 = l[0]; msb_first = m[0]; par_en = (pm != 0); par_odd = (pm == 2);
            wait_n(2);
            send(pats[k], 0, 1);
            check("R3 full set", full, 1);
            check("R4 data order/length", rdata, l[0] ? pats[k] : {1'b0, pats[k][6:0]});
            check("R6 no parity error", perr, 0);
            check("R8 no framing error", ferr, 0);
            read_byte();
            check("R5 read clears full", full, 0);
          end

    // R6: wrong parity, even and odd
    len8 = 1'b1; msb_first = 1'b0; par_en = 1'b1; par_odd = 1'b0; wait_n(2);
    send(8'h37, 1, 1);
    check("R6 even mismatch perr", perr, 1);
    check("R6 byte still delivered", rdata, 8'h37);
    read_byte(); clear_errs();
    check("R9 clear perr", perr, 0);
    par_odd = 1'b1; wait_n(2);
    send(8'h01, 1, 1);
    check("R6 odd mismatch perr", perr, 1);
    read_byte(); clear_errs();
    par_en = 1'b0; wait_n(2);

    // R8: low stop bit
    send(8'h6E, 0, 0);
    check("R8 ferr set", ferr, 1);
    check("R8 byte delivered", rdata, 8'h6E);
    check("R8 full", full, 1);
    read_byte(); wait_n(40); clear_errs();
    check("R9 clear ferr", ferr, 0);

    // R7: overrun keeps first byte
    send(8'h11, 0, 1);
    send(8'h22, 0, 1);
    check("R7 oerr set", oerr, 1);
    check("R7 first byte kept", rdata, 8'h11);

    // R10: interrupt gating
    check("R10 irq off when disabled", irq, 0);
    irq_en = 1'b1; wait_n(1);
    check("R10 irq with full", irq, 1);
    read_byte();
    check("R10 irq from error only", irq, 1);
    clear_errs();
    check("R9 clear oerr", oerr, 0);
    check("R10 irq idle", irq, 0);
    send(8'h44, 0, 1);
    check("R10 irq on new byte", irq, 1);
    read_byte();
    check("R10 irq after read", irq, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule